// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This block is a small 32-bit processor core that executes each instruction in one long clock cycle. It has two memory ports. The instruction port carries the program counter out as an address and takes a 32-bit instruction word back combinationally. The data port presents an address, write data and a write strobe, and takes read data back combinationally. The memories themselves sit outside the block.

In every cycle the core decodes the fetched word and reads up to two source registers. It then computes an ALU result, a memory address, or a branch or jump target. It commits the register write, the data write and the next program counter on the rising edge. The instruction set is small: word load and store; register-to-register add, subtract, AND, OR and signed set-less-than; branch on equality; and an absolute jump within the current 256 MB region.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter, and so the instruction address, to 0.
- R2: An instruction that is neither a taken branch nor a jump advances the program counter by 4.
- R3: R-type instructions (opcode 0x00, fields op[31:26], rs[25:21], rt[20:16], rd[15:11], shamt[10:6], funct[5:0]) write rd with rs+rt (funct 0x20), rs−rt (0x22), rs AND rt (0x24), rs OR rt (0x25), or 1/0 for a signed rs<rt (0x2A).
- R4: A load (opcode 0x23) reads the data word at rs plus the sign-extended offset[15:0] and writes it into rt.
- R5: A store (opcode 0x2B) drives that same address, drives rt as write data and raises the data write strobe without writing any register. The strobe stays low for every other opcode.
- R6: A branch (opcode 0x04) whose rs and rt values are equal sets the program counter to PC+4 plus the sign-extended offset shifted left by 2. Unequal values fall through to PC+4.
- R7: A jump (opcode 0x02) sets the program counter to PC[31:28], then the 26-bit index field[25:0], then two zero bits.
- R8: Register 0 always reads as zero, and a write to it has no effect.
- R9: Register and data memory writes take effect at the rising clock edge and become visible to the instruction in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Instruction fetch address (program counter) |
| imem_rdata | input | 32 | Fetched instruction word |
| dmem_addr | output | 32 | Data memory byte address |
| dmem_wdata | output | 32 | Data memory write data |
| dmem_we | output | 1 | Data memory write strobe |
| dmem_rdata | input | 32 | Data memory read data |

## Verification
The embedded assertions check four things on every cycle: the program counter after reset; its sequential, branch and jump updates against the fetched word; the data write strobe against the opcode; and the zero register on its read port. Only the bench's programs can show the arithmetic results, signed comparison, load data routing, discarded writes to register 0, and write-to-read forwarding across cycles. The bench runs these programs over a sweep of operand pairs that includes zero, −1 and the signed extremes. It then inspects what the core stores to data memory and where it finally parks the program counter.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] OPC_JMP   = 6'h02;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alu_op_e;

  typedef struct packed {
    logic    reg_we;
    logic    dst_is_rd;
    logic    wb_from_mem;
    logic    mem_we;
    logic    opb_is_imm;
    logic    is_branch;
    logic    is_jump;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  alu_op_e rtype_op;

  always_comb begin
    unique case (funct)
      FN_SUB:  rtype_op = ALU_SUB;
      FN_AND:  rtype_op = ALU_AND;
      FN_OR:   rtype_op = ALU_OR;
      FN_SLT:  rtype_op = ALU_SLT;
      default: rtype_op = ALU_ADD;
    endcase
  end

  always_comb begin
    ctrl = '{reg_we: 1'b0, dst_is_rd: 1'b0, wb_from_mem: 1'b0, mem_we: 1'b0,
             opb_is_imm: 1'b0, is_branch: 1'b0, is_jump: 1'b0, alu_op: ALU_ADD};
    case (opcode)
      OPC_RTYPE: begin
        ctrl.reg_we    = 1'b1;
        ctrl.dst_is_rd = 1'b1;
        ctrl.alu_op    = rtype_op;
      end
      OPC_LOAD: begin
        ctrl.reg_we      = 1'b1;
        ctrl.wb_from_mem = 1'b1;
        ctrl.opb_is_imm  = 1'b1;
      end
      OPC_STORE: begin
        ctrl.mem_we     = 1'b1;
        ctrl.opb_is_imm = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.is_branch = 1'b1;
        ctrl.alu_op    = ALU_SUB;
      end
      OPC_JMP: ctrl.is_jump = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   raddr_a,
  input  logic [AW-1:0]   raddr_b,
  output logic [XLEN-1:0] rdata_a,
  output logic [XLEN-1:0] rdata_b,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata
);
  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) regs[waddr] <= wdata;
  end

  assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];

  // R8
  zero_reg_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (raddr_b == '0) |-> (rdata_b == '0));
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y
);
  always_comb begin
    unique case (op)
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int RAW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] imem_addr,
  input  logic [31:0]     imem_rdata,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_we,
  input  logic [XLEN-1:0] dmem_rdata
);
  logic [XLEN-1:0] pc, pc_next, pc_inc, br_tgt, jmp_tgt;
  logic [XLEN-1:0] rs_val, rt_val, imm_ext, opb, alu_y, wb_data;
  logic [5:0]      opcode, funct;
  logic [RAW-1:0]  rs_idx, rt_idx, rd_idx, wb_idx;
  logic            take_br;
  ctrl_t           ctrl;

  assign opcode = imem_rdata[31:26];
  assign funct  = imem_rdata[5:0];
  assign rs_idx = imem_rdata[21 +: RAW];
  assign rt_idx = imem_rdata[16 +: RAW];
  assign rd_idx = imem_rdata[11 +: RAW];
  assign imm_ext = {{(XLEN-16){imem_rdata[15]}}, imem_rdata[15:0]};

  sc_decode u_dec (.opcode(opcode), .funct(funct), .ctrl(ctrl));

  assign wb_idx  = ctrl.dst_is_rd ? rd_idx : rt_idx;
  assign wb_data = ctrl.wb_from_mem ? dmem_rdata : alu_y;

  sc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk(clk), .rst(rst),
    .raddr_a(rs_idx), .raddr_b(rt_idx),
    .rdata_a(rs_val), .rdata_b(rt_val),
    .we(ctrl.reg_we && !rst), .waddr(wb_idx), .wdata(wb_data)
  );

  assign opb = ctrl.opb_is_imm ? imm_ext : rt_val;

  sc_alu #(.XLEN(XLEN)) u_alu (.op(ctrl.alu_op), .a(rs_val), .b(opb), .y(alu_y));

  assign pc_inc  = pc + XLEN'(4);
  assign br_tgt  = pc_inc + {imm_ext[XLEN-3:0], 2'b00};
  assign jmp_tgt = {pc[XLEN-1 -: 4], imem_rdata[25:0], 2'b00};
  assign take_br = ctrl.is_branch && (alu_y == '0);

  always_comb begin
    if (ctrl.is_jump)   pc_next = jmp_tgt;
    else if (take_br)   pc_next = br_tgt;
    else                pc_next = pc_inc;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next;
  end

  assign imem_addr  = pc;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_we    = ctrl.mem_we && !rst;

  // R1
  pc_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (imem_addr == '0));
  // R2
  pc_seq_chk: assert property (@(posedge clk) disable iff (rst)
    (opcode != OPC_BEQ && opcode != OPC_JMP) |=> (imem_addr == $past(imem_addr) + XLEN'(4)));
  // R6
  beq_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (opcode == OPC_BEQ && rs_val == rt_val) |=>
    (imem_addr == $past(imem_addr) + XLEN'(4) + {$past(imm_ext[XLEN-3:0]), 2'b00}));
  // R7
  pc_jump_chk: assert property (@(posedge clk) disable iff (rst)
    (opcode == OPC_JMP) |=>
    (imem_addr == {$past(imem_addr[XLEN-1 -: 4]), $past(imem_rdata[25:0]), 2'b00}));
  // R5
  store_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    dmem_we == (opcode == OPC_STORE));
endmodule

// File: tb/sc_core_tb_top.sv
`timescale 1ns/1ps
module sc_core_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];
  logic [31:0] seed_a, seed_b;
  int n_tests = 0, n_fail = 0;
  localparam logic [31:0] SENTINEL = 32'hDEADBEEF;

  always #4 clk = ~clk;

  sc_core dut_i (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata)
  );

  assign imem_rdata = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 64; i++) dmem[i] <= 32'h0;
      dmem[0] <= seed_a;
      dmem[1] <= seed_b;
      dmem[9] <= SENTINEL;
    end else if (dmem_we) begin
      dmem[dmem_addr[7:2]] <= dmem_wdata;
    end
  end

  function automatic logic [31:0] rop(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] iop(input logic [5:0] op, input int rs, input int rt, input int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] vals [6];
    vals = '{32'h0, 32'h1, 32'hFFFFFFFF, 32'h7FFFFFFF, 32'h80000000, 32'h5};
    for (int i = 0; i < 64; i++) imem[i] = 32'h0;
    imem[0]  = iop(6'h23, 0, 1, 0);        // R4 lw r1,0(r0)
    imem[1]  = iop(6'h23, 0, 2, 4);        // lw r2,4(r0)
    imem[2]  = rop(1, 2, 3, 6'h20);        // add
    imem[3]  = rop(1, 2, 4, 6'h22);        // sub
    imem[4]  = rop(1, 2, 5, 6'h24);        // and
    imem[5]  = rop(1, 2, 6, 6'h25);        // or
    imem[6]  = rop(1, 2, 7, 6'h2A);        // slt
    imem[7]  = iop(6'h2B, 0, 3, 16);
    imem[8]  = iop(6'h2B, 0, 4, 20);
    imem[9]  = iop(6'h2B, 0, 5, 24);
    imem[10] = iop(6'h2B, 0, 6, 28);
    imem[11] = iop(6'h2B, 7, 7, 32 - 0);   // base r7 (0/1) not used: overwritten below
    imem[11] = iop(6'h2B, 0, 7, 32);
    imem[12] = iop(6'h04, 1, 2, 1);        // R6 beq skip one
    imem[13] = iop(6'h2B, 0, 1, 36);
    imem[14] = rop(1, 2, 0, 6'h20);        // R8 write r0
    imem[15] = iop(6'h2B, 0, 0, 40);
    imem[16] = {6'h02, 26'd16};            // R7 jump to self
    foreach (vals[ia]) begin
      foreach (vals[ib]) begin
        logic [31:0] a, b;
        a = vals[ia]; b = vals[ib];
        seed_a = a; seed_b = b;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        check("R1 pc after reset", imem_addr, 32'h0);
        @(negedge clk);
        check("R2 pc step", imem_addr, 32'h4);
        @(negedge clk);
        check("R2 pc step", imem_addr, 32'h8);
        repeat (23) @(negedge clk);
        check("R3/R9 add", dmem[4], a + b);
        check("R3 sub", dmem[5], a - b);
        check("R3 and", dmem[6], a & b);
        check("R3 or", dmem[7], a | b);
        check("R3 slt", dmem[8], {31'h0, $signed(a) < $signed(b)});
        check("R6 beq", dmem[9], (a == b) ? SENTINEL : a);
        check("R8 r0", dmem[10], 32'h0);
        check("R4 load kept", dmem[0], a);
        check("R5 no stray store", dmem[11], 32'h0);
        check("R7 jump", imem_addr, 32'h40);
      end
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule